// File: doc/BRIEF.md
# Posted-Write Pending Tracker

This block sits between a register port clocked by the bus clock and a timer core that runs on a slower, unrelated functional clock. Ten of the timer's registers are synchronised. A bus write to one of them is captured on the bus side, and the capture flips a request toggle. A two-flop synchroniser carries that toggle into the functional domain, where the value is applied to the core. An acknowledge toggle then returns over a second two-flop synchroniser. Until the acknowledge arrives, the pending flag for that register stays set. Software reads all ten flags as one status word and polls it before it touches the same register again.

The functional side hands values to the core one at a time, through a single strobe, selector and data port. The lowest register index goes first. A write to the trigger register is never passed on as its own value. It is turned into a reload of the counter from the most recently applied load value.

An interface-control register sets posted mode and comes out of reset with posted mode on. With posted mode off, writes to synchronised registers become blocking: the bus ready output is held low until the functional domain has acknowledged the write. A write that arrives while its register's flag is still set is discarded, and an error pulse is raised.

Top module: `posted_wr_tracker`

## Requirements
- R1: Out of reset, pend_flags is 0, bus_ready is 1 while idle, bus_err is 0, func_wr_valid is 0, and reading address 16 returns 0x4 (posted mode on).
- R2: A write to address i (0..9) whose pending flag is clear sets pend_flags bit i from the bus edge that accepts the write, and leaves the other bits unchanged. The bit order is: 0 control, 1 counter, 2 load, 3 trigger, 4 match, 5 positive tick increment, 6 negative tick increment, 7 tick count, 8 interrupt-mask set, 9 interrupt-mask count.
- R3: A pending flag is still set one bus cycle after its write. It clears only after the functional side has issued one func_wr_valid pulse with func_wr_sel = i and func_wr_data equal to the written value.
- R4: A write to a register whose flag is set is discarded. Only the first value is delivered, and it is delivered exactly once.
- R5: A discarded write raises bus_err for exactly one bus cycle, starting at the edge that discarded the write.
- R6: A write to the trigger register (address 3) is delivered as func_wr_sel = 1 (counter), with data equal to the last value delivered for the load register (address 2). The data written to the trigger register has no effect.
- R7: When several registers are waiting in the same functional cycle, one delivery is made per functional cycle, in ascending index order, on consecutive cycles.
- R8: A write to address 16 takes bit 2 of the write data as the posted-mode enable. The effect is immediate and no pending flag is set. A read of address 16 returns that bit in position 2 and zeros in every other bit.
- R9: With posted mode off, a write to a synchronised register sees bus_ready low from its first cycle until its pending flag clears, and then completes. With posted mode on, such a write completes in its first cycle.
- R10: A read of address 17 returns pend_flags in bits 9..0 and zeros above them.
- R11: A write to any other address sets no flag, produces no delivery and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| func_clk | input | 1 | Functional-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised in each domain |
| bus_wr_en | input | 1 | Write request; held until bus_ready is high |
| bus_addr | input | 5 | Register address: 0..9 synchronised registers, 16 interface control, 17 pending status |
| bus_wdata | input | DW | Write data |
| bus_ready | output | 1 | Transfer completes on a bus edge where this is high |
| bus_err | output | 1 | One-cycle pulse after a write is discarded |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| pend_flags | output | 10 | One pending flag per synchronised register |
| func_wr_valid | output | 1 | A value is being applied to the core in this functional cycle |
| func_wr_sel | output | 4 | Index of the core register being written |
| func_wr_data | output | DW | Value applied to the core |

## Verification
The pending flag and the read data change at the bus edge that accepts a write, and the bench checks them at the negedge that follows. bus_err is due one bus cycle after a discarded write and must be gone one cycle later. A delivery appears three functional edges after a write: two synchroniser stages, then the registered output. The flag clears two bus edges after that. Because the two clocks are unrelated, these counts are covered by bounded polls, and checks run only once the flags have cleared. For the ordering test the bench stops the functional clock while it queues writes, so all of them arrive on the same cycle and the order of deliveries is fixed.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int unsigned NUM_SYNC   = 10;
  localparam int unsigned SEL_W      = $clog2(NUM_SYNC);
  localparam int unsigned IDX_SPAN   = 1 << SEL_W;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned POSTED_BIT = 2;

  localparam logic [ADDR_W-1:0] ADDR_IFCTRL = 5'd16;
  localparam logic [ADDR_W-1:0] ADDR_WPEND  = 5'd17;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL     = 4'd0,
    SEL_COUNTER  = 4'd1,
    SEL_LOAD     = 4'd2,
    SEL_TRIGGER  = 4'd3,
    SEL_MATCH    = 4'd4,
    SEL_TICK_POS = 4'd5,
    SEL_TICK_NEG = 4'd6,
    SEL_TICK_CNT = 4'd7,
    SEL_MASK_SET = 4'd8,
    SEL_MASK_CNT = 4'd9
  } sync_sel_e;
endpackage

// File: rtl/wpt_rst_sync.sv
module wpt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] shift_q;
  logic [1:0] shift_d;

  always_comb shift_d = {shift_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign rst_n_o = shift_q[1];
endmodule

// File: rtl/wpt_sync2.sv
module wpt_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/wpt_bus_side.sv
module wpt_bus_side
  import wpt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                           bus_clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DW-1:0]                  wdata,
  input  logic [NUM_SYNC-1:0]            ack_sync,
  output logic                           ready,
  output logic                           err,
  output logic [DW-1:0]                  rdata,
  output logic [NUM_SYNC-1:0]            pend,
  output logic [NUM_SYNC-1:0]            req_tgl,
  output logic [NUM_SYNC-1:0][DW-1:0]    hold_data
);
  logic [NUM_SYNC-1:0]         req_q, req_d;
  logic [NUM_SYNC-1:0][DW-1:0] data_q, data_d;
  logic                        busy_q, busy_d;
  logic [SEL_W-1:0]            bidx_q, bidx_d;
  logic                        posted_q, posted_d;
  logic                        err_q, err_d;

  logic [IDX_SPAN-1:0] pend_ext;
  logic [SEL_W-1:0]    idx;
  logic                addr_is_sync;
  logic                hit_pend;
  logic                accept;
  logic                drop;
  logic                ifc_wr;

  assign pend         = req_q ^ ack_sync;
  assign pend_ext     = IDX_SPAN'(pend);
  assign idx          = addr[SEL_W-1:0];
  assign addr_is_sync = (addr < ADDR_W'(NUM_SYNC));
  assign hit_pend     = addr_is_sync && pend_ext[idx];
  assign accept       = wr_en && !busy_q && addr_is_sync && !hit_pend;
  assign drop         = wr_en && !busy_q && hit_pend;
  assign ifc_wr       = wr_en && !busy_q && (addr == ADDR_IFCTRL);

  always_comb begin
    if (busy_q) ready = !pend_ext[bidx_q];
    else        ready = !(accept && !posted_q);
  end

  always_comb begin
    req_d    = req_q;
    data_d   = data_q;
    busy_d   = busy_q;
    bidx_d   = bidx_q;
    posted_d = posted_q;
    err_d    = drop;
    for (int i = 0; i < NUM_SYNC; i++) begin
      if (accept && (idx == SEL_W'(i))) begin
        req_d[i]  = ~req_q[i];
        data_d[i] = wdata;
      end
    end
    if (busy_q) begin
      if (!pend_ext[bidx_q]) busy_d = 1'b0;
    end else if (accept && !posted_q) begin
      busy_d = 1'b1;
      bidx_d = idx;
    end
    if (ifc_wr) posted_d = wdata[POSTED_BIT];
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= '0;
      data_q   <= '0;
      busy_q   <= 1'b0;
      bidx_q   <= '0;
      posted_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      req_q    <= req_d;
      data_q   <= data_d;
      busy_q   <= busy_d;
      bidx_q   <= bidx_d;
      posted_q <= posted_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_IFCTRL)     rdata[POSTED_BIT]     = posted_q;
    else if (addr == ADDR_WPEND) rdata[NUM_SYNC-1:0]   = pend;
  end

  assign err       = err_q;
  assign req_tgl   = req_q;
  assign hold_data = data_q;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_chk
    // R2
    pend_rise_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      $rose(pend[g]) |-> $past(wr_en && !busy_q && (addr == ADDR_W'(g))));
    // R4
    hold_stable_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (pend[g] && $past(pend[g])) |-> $stable(data_q[g]));
  end

  // R5
  err_src_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    err |-> $past(wr_en && addr_is_sync));

  // R9
  blk_done_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (busy_q && ready) |=> (!busy_q && !pend_ext[$past(bidx_q)]));
endmodule

// File: rtl/wpt_func_side.sv
module wpt_func_side
  import wpt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                        func_clk,
  input  logic                        rst_n,
  input  logic [NUM_SYNC-1:0]         req_sync,
  input  logic [NUM_SYNC-1:0][DW-1:0] hold_data,
  output logic [NUM_SYNC-1:0]         ack_tgl,
  output logic                        valid,
  output logic [SEL_W-1:0]            sel,
  output logic [DW-1:0]               data
);
  logic [NUM_SYNC-1:0] ack_q, ack_d;
  logic                valid_q, valid_d;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic [DW-1:0]       data_q, data_d;
  logic [DW-1:0]       shadow_q, shadow_d;

  logic [NUM_SYNC-1:0] waiting;
  logic [NUM_SYNC-1:0] grant;
  logic [SEL_W-1:0]    gidx;
  logic [DW-1:0]       gdata;
  logic                found;

  assign waiting = req_sync ^ ack_q;

  always_comb begin
    grant = '0;
    gidx  = '0;
    gdata = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SYNC; i++) begin
      if (waiting[i] && !found) begin
        grant[i] = 1'b1;
        gidx     = SEL_W'(i);
        gdata    = hold_data[i];
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    ack_d    = ack_q ^ grant;
    valid_d  = found;
    sel_d    = sel_q;
    data_d   = data_q;
    shadow_d = shadow_q;
    if (found) begin
      if (gidx == SEL_TRIGGER) begin
        sel_d  = SEL_COUNTER;
        data_d = shadow_q;
      end else begin
        sel_d  = gidx;
        data_d = gdata;
      end
      if (gidx == SEL_LOAD) shadow_d = gdata;
    end
  end

  always_ff @(posedge func_clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= '0;
      valid_q  <= 1'b0;
      sel_q    <= '0;
      data_q   <= '0;
      shadow_q <= '0;
    end else begin
      ack_q    <= ack_d;
      valid_q  <= valid_d;
      sel_q    <= sel_d;
      data_q   <= data_d;
      shadow_q <= shadow_d;
    end
  end

  assign ack_tgl = ack_q;
  assign valid   = valid_q;
  assign sel     = sel_q;
  assign data    = data_q;

  // R7
  one_apply_chk: assert property (@(posedge func_clk) disable iff (!rst_n)
    $countones(ack_q ^ $past(ack_q)) <= 1);

  // R3
  deliver_src_chk: assert property (@(posedge func_clk) disable iff (!rst_n)
    valid |-> $past(req_sync != ack_q));
endmodule

// File: rtl/posted_wr_tracker.sv
module posted_wr_tracker
  import wpt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                bus_clk,
  input  logic                func_clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic                bus_ready,
  output logic                bus_err,
  output logic [DW-1:0]       bus_rdata,
  output logic [NUM_SYNC-1:0] pend_flags,
  output logic                func_wr_valid,
  output logic [SEL_W-1:0]    func_wr_sel,
  output logic [DW-1:0]       func_wr_data
);
  logic                        bus_rst_n;
  logic                        func_rst_n;
  logic [NUM_SYNC-1:0]         req_tgl;
  logic [NUM_SYNC-1:0]         req_sync;
  logic [NUM_SYNC-1:0]         ack_tgl;
  logic [NUM_SYNC-1:0]         ack_sync;
  logic [NUM_SYNC-1:0][DW-1:0] hold_data;

  wpt_rst_sync u_bus_rst (.clk(bus_clk),  .arst_n(rst_n), .rst_n_o(bus_rst_n));
  wpt_rst_sync u_fn_rst  (.clk(func_clk), .arst_n(rst_n), .rst_n_o(func_rst_n));

  wpt_bus_side #(.DW(DW)) u_bus (
    .bus_clk   (bus_clk),
    .rst_n     (bus_rst_n),
    .wr_en     (bus_wr_en),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .ack_sync  (ack_sync),
    .ready     (bus_ready),
    .err       (bus_err),
    .rdata     (bus_rdata),
    .pend      (pend_flags),
    .req_tgl   (req_tgl),
    .hold_data (hold_data)
  );

  wpt_sync2 #(.W(NUM_SYNC)) u_req_sync (
    .clk(func_clk), .rst_n(func_rst_n), .d(req_tgl), .q(req_sync)
  );

  wpt_sync2 #(.W(NUM_SYNC)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_sync)
  );

  wpt_func_side #(.DW(DW)) u_func (
    .func_clk  (func_clk),
    .rst_n     (func_rst_n),
    .req_sync  (req_sync),
    .hold_data (hold_data),
    .ack_tgl   (ack_tgl),
    .valid     (func_wr_valid),
    .sel       (func_wr_sel),
    .data      (func_wr_data)
  );
endmodule

// File: tb/posted_wr_tracker_tb.sv
module posted_wr_tracker_tb;
  localparam int BUS_PERIOD  = 10;
  localparam int FUNC_PERIOD = 26;

  logic        bus_clk = 1'b0;
  logic        func_clk = 1'b0;
  logic        fclk_run = 1'b1;
  logic        rst_n;
  logic        bus_wr_en;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic        bus_err;
  logic [31:0] bus_rdata;
  logic [9:0]  pend_flags;
  logic        func_wr_valid;
  logic [3:0]  func_wr_sel;
  logic [31:0] func_wr_data;

  int checks = 0;
  int errors = 0;
  int fcyc = 0;
  int log_cnt = 0;
  logic [3:0]  log_sel  [0:63];
  logic [31:0] log_data [0:63];
  int          log_cyc  [0:63];

  posted_wr_tracker u_dut (
    .bus_clk(bus_clk), .func_clk(func_clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .pend_flags(pend_flags), .func_wr_valid(func_wr_valid),
    .func_wr_sel(func_wr_sel), .func_wr_data(func_wr_data)
  );

  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
  always begin
    #(FUNC_PERIOD/2);
    if (fclk_run) func_clk = ~func_clk;
  end

  always @(negedge func_clk) begin
    fcyc++;
    if (rst_n && func_wr_valid && log_cnt < 64) begin
      log_sel[log_cnt]  = func_wr_sel;
      log_data[log_cnt] = func_wr_data;
      log_cyc[log_cnt]  = fcyc;
      log_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d,
                           output int low, output logic err_seen);
    @(negedge bus_clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    low = 0;
    while (!bus_ready) begin
      @(negedge bus_clk);
      low++;
    end
    @(negedge bus_clk);
    err_seen = bus_err;
    bus_wr_en = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (pend_flags != 10'd0 && n < 400) begin
      @(negedge bus_clk);
      n++;
    end
    chk(pend_flags == 10'd0, req, 32'(pend_flags), 32'h0);
    repeat (4) @(negedge bus_clk);
  endtask

  task automatic t_reset();
    bus_addr = 5'd16; #1;
    chk(pend_flags == 10'd0, "R1 pend", 32'(pend_flags), 32'h0);
    chk(bus_ready == 1'b1, "R1 ready", 32'(bus_ready), 32'h1);
    chk(bus_err == 1'b0, "R1 err", 32'(bus_err), 32'h0);
    chk(func_wr_valid == 1'b0, "R1 valid", 32'(func_wr_valid), 32'h0);
    chk(bus_rdata == 32'h4, "R1 posted", bus_rdata, 32'h4);
  endtask

  task automatic t_single();
    int low; logic e; int base = log_cnt;
    bus_write(5'd0, 32'hA5A5_0001, low, e);
    chk(pend_flags == 10'h001, "R2 set", 32'(pend_flags), 32'h1);
    chk(low == 0, "R9 posted first cycle", 32'(low), 32'h0);
    @(negedge bus_clk);
    chk(pend_flags[0] == 1'b1, "R3 still set", 32'(pend_flags), 32'h1);
    wait_idle("R3 clears");
    chk(log_cnt == base + 1, "R3 count", 32'(log_cnt - base), 32'h1);
    chk(log_sel[base] == 4'd0 && log_data[base] == 32'hA5A5_0001, "R3 delivery",
        log_data[base], 32'hA5A5_0001);
  endtask

  task automatic t_drop();
    int low; logic e; int base = log_cnt;
    bus_write(5'd4, 32'h0000_B0B0, low, e);
    chk(e == 1'b0, "R5 no err on clean write", 32'(e), 32'h0);
    bus_write(5'd4, 32'h0000_C0C0, low, e);
    chk(e == 1'b1, "R5 err raised", 32'(e), 32'h1);
    @(negedge bus_clk);
    chk(bus_err == 1'b0, "R5 err one cycle", 32'(bus_err), 32'h0);
    wait_idle("R4 idle");
    chk(log_cnt == base + 1, "R4 single delivery", 32'(log_cnt - base), 32'h1);
    chk(log_sel[base] == 4'd4 && log_data[base] == 32'h0000_B0B0, "R4 first value kept",
        log_data[base], 32'h0000_B0B0);
  endtask

  task automatic t_trigger();
    int low; logic e; int base;
    bus_write(5'd2, 32'h1234_5678, low, e);
    wait_idle("R6 load idle");
    base = log_cnt;
    bus_write(5'd3, 32'hDEAD_BEEF, low, e);
    wait_idle("R6 trig idle");
    chk(log_cnt == base + 1, "R6 count", 32'(log_cnt - base), 32'h1);
    chk(log_sel[base] == 4'd1, "R6 counter sel", 32'(log_sel[base]), 32'h1);
    chk(log_data[base] == 32'h1234_5678, "R6 reload value", log_data[base], 32'h1234_5678);
  endtask

  task automatic t_priority();
    int low; logic e; int base = log_cnt;
    logic [3:0]  exp_sel [0:3];
    logic [31:0] exp_dat [0:3];
    exp_sel[0] = 4'd0; exp_sel[1] = 4'd5; exp_sel[2] = 4'd7; exp_sel[3] = 4'd9;
    exp_dat[0] = 32'h10; exp_dat[1] = 32'h15; exp_dat[2] = 32'h17; exp_dat[3] = 32'h19;
    @(negedge func_clk);
    fclk_run = 1'b0;
    bus_write(5'd9, 32'h19, low, e);
    bus_write(5'd7, 32'h17, low, e);
    bus_write(5'd5, 32'h15, low, e);
    bus_write(5'd0, 32'h10, low, e);
    chk(pend_flags == 10'h2A1, "R2 multi set", 32'(pend_flags), 32'h2A1);
    fclk_run = 1'b1;
    wait_idle("R7 idle");
    chk(log_cnt == base + 4, "R7 count", 32'(log_cnt - base), 32'h4);
    for (int k = 0; k < 4; k++) begin
      chk(log_sel[base+k] == exp_sel[k] && log_data[base+k] == exp_dat[k], "R7 order",
          32'(log_sel[base+k]), 32'(exp_sel[k]));
      chk(log_cyc[base+k] == log_cyc[base] + k, "R7 consecutive",
          32'(log_cyc[base+k] - log_cyc[base]), 32'(k));
    end
  endtask

  task automatic t_blocking();
    int low; logic e; int base;
    bus_write(5'd16, 32'hFFFF_FFFB, low, e);
    chk(low == 0 && pend_flags == 10'd0, "R8 no pend", 32'(pend_flags), 32'h0);
    bus_addr = 5'd16; #1;
    chk(bus_rdata == 32'h0, "R8 readback off", bus_rdata, 32'h0);
    base = log_cnt;
    bus_write(5'd8, 32'h0000_0E0E, low, e);
    chk(low >= 2, "R9 ready held low", 32'(low), 32'h2);
    chk(pend_flags == 10'd0, "R9 done when clear", 32'(pend_flags), 32'h0);
    chk(log_cnt == base + 1 && log_sel[base] == 4'd8 && log_data[base] == 32'h0E0E,
        "R3 blocking delivery", log_data[base], 32'h0E0E);
    bus_write(5'd16, 32'h0000_0004, low, e);
    bus_addr = 5'd16; #1;
    chk(bus_rdata == 32'h4, "R8 readback on", bus_rdata, 32'h4);
    bus_write(5'd6, 32'h0000_0606, low, e);
    chk(low == 0, "R9 posted again", 32'(low), 32'h0);
    wait_idle("R9 idle");
  endtask

  task automatic t_status_read();
    int low; logic e;
    bus_write(5'd5, 32'h0000_0505, low, e);
    bus_addr = 5'd17; #1;
    chk(bus_rdata == 32'h0000_0020, "R10 status word", bus_rdata, 32'h20);
    wait_idle("R10 idle");
    bus_addr = 5'd17; #1;
    chk(bus_rdata == 32'h0, "R10 status clear", bus_rdata, 32'h0);
  endtask

  task automatic t_other_addr();
    int low; logic e; int base = log_cnt;
    bus_write(5'd20, 32'hFFFF_FFFF, low, e);
    chk(e == 1'b0, "R11 no err", 32'(e), 32'h0);
    chk(pend_flags == 10'd0, "R11 no pend", 32'(pend_flags), 32'h0);
    repeat (30) @(negedge bus_clk);
    chk(log_cnt == base, "R11 no delivery", 32'(log_cnt - base), 32'h0);
  endtask

  initial begin
    #(BUS_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    #(BUS_PERIOD * 6);
    rst_n = 1'b1;
    repeat (10) @(negedge bus_clk);
    t_reset();
    t_single();
    t_drop();
    t_trigger();
    t_priority();
    t_blocking();
    t_status_read();
    t_other_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule